// File: doc/BRIEF.md
# Two-Wire Command Slave

This block is the slave end of a two-wire serial bus (I2C-style) for a small peripheral. It oversamples the clock line and the data line with the system clock and finds start, repeated-start and stop conditions. It then decodes the address byte that follows a start and takes part in the transfer only when the address matches. The seven-bit address has five fixed upper bits. Its two low bits come from strap inputs, so that four copies of the block can share one bus.

A master write carries exactly one command byte and no register address. That byte is handed to the surrounding logic on a parallel output, together with a one-cycle valid strobe. A master read returns up to two bytes. Both bytes are captured from a parallel input at the moment the address is acknowledged, so they are coherent with each other. The data line is never driven high. The block only asserts a pull-low enable, and it changes that enable only while the clock line is low.

Top module: `twi_cmd_slave`

## Requirements
- R1: A falling data edge while the clock line is high is a start condition. A start received anywhere, including in the middle of a byte, restarts address reception, so a complete address byte sent after it is decoded normally.
- R2: A rising data edge while the clock line is high is a stop condition. After a stop, the block neither acknowledges nor drives any byte until the next start, even when a matching address is clocked in.
- R3: The first byte after a start is the address. Bits 7..1 are compared with {5'b10010, strap_i[1:0]}, and bit 0 selects the direction (1 = master reads, 0 = master writes). On a match, sda_pull_o holds the data line low during the ninth clock. On a mismatch, the line stays released for that clock and for every later byte of the transaction.
- R4: In a write, the byte after the address is shifted in MSB first and acknowledged. It then appears on cmd_o together with a cmd_valid_o pulse that lasts exactly one clk cycle.
- R5: Any further byte in the same write is not acknowledged. It leaves cmd_o unchanged and raises no cmd_valid_o pulse.
- R6: In a read, the slave sends rd_data_i[15:8] first and rd_data_i[7:0] second, each MSB first. A low data line from the master in the acknowledge slot continues the transfer. A high data line ends it, after which the slave leaves the line released.
- R7: If the master acknowledges the second byte, the slave releases the line for the rest of the transaction, so any further byte reads as 0xFF.
- R8: Both read bytes are taken from rd_data_i at the address acknowledge. A change of rd_data_i after that point does not affect the bytes sent.
- R9: sda_pull_o changes only while the clock line is low.
- R10: While rst is high and right after it, sda_pull_o and cmd_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Low two bits of the slave address |
| rd_data_i | input | 16 | Read data; bits 15:8 are sent first |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |
| cmd_o | output | 8 | Last accepted command byte |
| cmd_valid_o | output | 1 | One-cycle strobe for a new command byte |

## Verification
Every bus edge passes through two synchroniser flops and one edge register. The slave's pull enable therefore changes about three system clocks after the bus clock falls. The bench holds each bus clock phase for eight system clocks and reads the data line halfway through the high phase, well after any response has settled. The command strobe is due a few cycles after the eighth falling edge of the command byte. Because of that, a monitor counts strobes and latches cmd_o on every cycle, and each task compares the strobe count and the latched value once its transaction is complete. The rule that the pull enable only moves while the clock is low is watched on every cycle for the whole run and checked at the end.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int STRAP_W  = 2;
    localparam int FIXED_W  = ADDR_W - STRAP_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } twi_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic scl_hi;
        logic sda;
        logic start;
        logic stop;
    } twi_bus_ev_t;

    function automatic logic addr_hit(
        input logic [ADDR_W-1:0]  rx_addr,
        input logic [FIXED_W-1:0] fixed_hi,
        input logic [STRAP_W-1:0] strap
    );
        return rx_addr == {fixed_hi, strap};
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events
    import twi_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_s,
    input  logic        sda_s,
    output twi_bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.scl_hi   = scl_s;
        ev.sda      = sda_s;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_cmd_pkg::*;
#(
    parameter logic [FIXED_W-1:0] FIXED_ADDR = 5'b10010,
    parameter int                 RD_BYTES   = 2,
    localparam int                RD_W       = RD_BYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  twi_bus_ev_t        ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic [RD_W-1:0]    rd_data,
    output logic               sda_pull,
    output logic [BYTE_W-1:0]  cmd,
    output logic               cmd_valid
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int IDX_W = $clog2(RD_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(RD_BYTES);

    twi_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-2:0] tx_rest;
    logic [RD_W-1:0]   rd_buf;
    logic [IDX_W-1:0]  rd_idx;
    logic              is_read;
    logic              cmd_taken;
    logic              master_ack;
    logic [BYTE_W-1:0] head_byte;

    assign head_byte = rd_buf[RD_W-1 -: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            tx_rest    <= '0;
            rd_buf     <= '0;
            rd_idx     <= '0;
            is_read    <= 1'b0;
            cmd_taken  <= 1'b0;
            master_ack <= 1'b0;
            sda_pull   <= 1'b0;
            cmd        <= '0;
            cmd_valid  <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (ev.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall && bit_cnt == CNT_FULL) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg[BYTE_W-1:1], FIXED_ADDR, strap)) begin
                                    sda_pull  <= 1'b1;
                                    state     <= ST_ADDR_ACK;
                                    is_read   <= shreg[0];
                                    cmd_taken <= 1'b0;
                                    if (shreg[0]) rd_buf <= rd_data;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                state <= ST_WR_ACK;
                                if (!cmd_taken) begin
                                    sda_pull  <= 1'b1;
                                    cmd       <= shreg;
                                    cmd_valid <= 1'b1;
                                    cmd_taken <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                sda_pull <= ~head_byte[BYTE_W-1];
                                tx_rest  <= head_byte[BYTE_W-2:0];
                                rd_buf   <= rd_buf << BYTE_W;
                                rd_idx   <= IDX_W'(1);
                                state    <= ST_RD_BYTE;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_fall) begin
                            if (bit_cnt == CNT_LAST) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RD_ACK;
                            end else begin
                                sda_pull <= ~tx_rest[BYTE_W-2];
                                tx_rest  <= {tx_rest[BYTE_W-3:0], 1'b1};
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            master_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (master_ack && rd_idx < IDX_END) begin
                                bit_cnt  <= '0;
                                sda_pull <= ~head_byte[BYTE_W-1];
                                tx_rest  <= head_byte[BYTE_W-2:0];
                                rd_buf   <= rd_buf << BYTE_W;
                                rd_idx   <= rd_idx + 1'b1;
                                state    <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    pull_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_hi && !ev.start && !ev.stop) |=> $stable(sda_pull));

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_pull));

    // R1
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && bit_cnt == '0));

    // R4
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R5
    first_cmd_only_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(cmd_taken));

    // R3
    mismatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE && $past(state) == ST_ADDR) |-> !sda_pull);

endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
    import twi_cmd_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 RD_BYTES    = 2,
    parameter logic [FIXED_W-1:0] FIXED_ADDR  = 5'b10010,
    localparam int                RD_W        = RD_BYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [RD_W-1:0]    rd_data_i,
    output logic               sda_pull_o,
    output logic [BYTE_W-1:0]  cmd_o,
    output logic               cmd_valid_o
);

    logic [1:0]  lines_s;
    twi_bus_ev_t ev;

    twi_line_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );

    twi_bus_events events_i (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    twi_slave_fsm #(
        .FIXED_ADDR (FIXED_ADDR),
        .RD_BYTES   (RD_BYTES)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap_i),
        .rd_data   (rd_data_i),
        .sda_pull  (sda_pull_o),
        .cmd       (cmd_o),
        .cmd_valid (cmd_valid_o)
    );

endmodule

// File: tb/twi_cmd_slave_tb_top.sv
module twi_cmd_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        scl_drv;
    logic        sda_drv;
    logic [1:0]  strap;
    logic [15:0] rd_data;
    logic        sda_pull;
    logic [7:0]  cmd;
    logic        cmd_valid;
    logic        sda_line;

    int n_checks = 0;
    int n_fails  = 0;
    int valid_cnt = 0;
    logic [7:0] last_cmd = 8'h00;
    int r9_viol = 0;
    int pull_cycles = 0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    twi_cmd_slave dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_drv),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .rd_data_i   (rd_data),
        .sda_pull_o  (sda_pull),
        .cmd_o       (cmd),
        .cmd_valid_o (cmd_valid)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                valid_cnt++;
                last_cmd = cmd;
            end
            if (scl_drv && prev_scl && sda_pull != prev_pull) r9_viol++;
            if (sda_pull) pull_cycles++;
        end
        prev_scl  = scl_drv;
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rw);
        return {5'b10010, s, rw};
    endfunction

    task automatic bus_start();
        if (!scl_drv) begin
            wclk(2); sda_drv = 1'b1; wclk(6);
            scl_drv = 1'b1; wclk(8);
        end
        sda_drv = 1'b0; wclk(8);
        scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(2); sda_drv = 1'b0; wclk(6);
        scl_drv = 1'b1; wclk(8);
        sda_drv = 1'b1; wclk(8);
    endtask

    task automatic put_bit(input logic b);
        wclk(2); sda_drv = b; wclk(6);
        scl_drv = 1'b1; wclk(8);
        scl_drv = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wclk(2); sda_drv = 1'b1; wclk(6);
        scl_drv = 1'b1; wclk(4);
        b = sda_line; wclk(4);
        scl_drv = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = (a == 1'b0);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1; scl_drv = 1'b1; sda_drv = 1'b1; strap = 2'b00; rd_data = 16'h0000;
        wclk(4);
        chk(sda_pull == 1'b0, "R10 pull in reset", 32'(sda_pull), 0);
        rst = 1'b0;
        wclk(4);
        chk(sda_pull == 1'b0 && cmd_valid == 1'b0, "R10 idle after reset",
            {30'd0, sda_pull, cmd_valid}, 0);
    endtask

    task automatic t_write(input logic [1:0] s, input logic [7:0] c);
        bit a1, a2;
        int v0;
        strap = s;
        v0 = valid_cnt;
        bus_start();
        put_byte(addr_byte(s, 1'b0), a1);
        chk(a1, "R3 write address ack", 32'(a1), 1);
        put_byte(c, a2);
        chk(a2, "R4 command ack", 32'(a2), 1);
        bus_stop();
        chk(valid_cnt == v0 + 1, "R4 one strobe", 32'(valid_cnt - v0), 1);
        chk(last_cmd == c && cmd == c, "R4 command value", 32'(last_cmd), 32'(c));
        chk(sda_pull == 1'b0, "R2 released after stop", 32'(sda_pull), 0);
    endtask

    task automatic t_bad_addr(input logic [7:0] ab, input string tag);
        bit a1, a2;
        int v0, p0;
        v0 = valid_cnt;
        p0 = pull_cycles;
        bus_start();
        put_byte(ab, a1);
        put_byte(8'h5A, a2);
        bus_stop();
        chk(!a1, {"R3 mismatch nack ", tag}, 32'(a1), 0);
        chk(!a2 && pull_cycles == p0, {"R3 ignore rest ", tag}, 32'(pull_cycles - p0), 0);
        chk(valid_cnt == v0, {"R3 no strobe ", tag}, 32'(valid_cnt - v0), 0);
    endtask

    task automatic t_extra_cmd();
        bit a1, a2, a3;
        int v0;
        strap = 2'b10;
        v0 = valid_cnt;
        bus_start();
        put_byte(addr_byte(2'b10, 1'b0), a1);
        put_byte(8'hC3, a2);
        put_byte(8'h3C, a3);
        bus_stop();
        chk(a1 && a2, "R4 first cmd acked", {30'd0, a1, a2}, 3);
        chk(!a3, "R5 extra byte nack", 32'(a3), 0);
        chk(valid_cnt == v0 + 1 && cmd == 8'hC3, "R5 cmd unchanged", 32'(cmd), 32'hC3);
    endtask

    task automatic t_read(input logic [15:0] d, input int nbytes);
        bit a1;
        logic [7:0] b0, b1, bx;
        strap = 2'b01;
        rd_data = d;
        bus_start();
        put_byte(addr_byte(2'b01, 1'b1), a1);
        chk(a1, "R3 read address ack", 32'(a1), 1);
        get_byte(nbytes > 1, b0);
        chk(b0 == d[15:8], "R6 first byte", 32'(b0), 32'(d[15:8]));
        if (nbytes > 1) begin
            get_byte(nbytes > 2, b1);
            chk(b1 == d[7:0], "R6 second byte", 32'(b1), 32'(d[7:0]));
        end
        get_byte(1'b0, bx);
        if (nbytes > 2)
            chk(bx == 8'hFF, "R7 past last byte", 32'(bx), 32'hFF);
        else
            chk(bx == 8'hFF, "R6 released after nack", 32'(bx), 32'hFF);
        bus_stop();
    endtask

    task automatic t_coherent();
        bit a1;
        logic [7:0] b0, b1;
        strap = 2'b11;
        rd_data = 16'hA55A;
        bus_start();
        put_byte(addr_byte(2'b11, 1'b1), a1);
        rd_data = 16'h1234;
        get_byte(1'b1, b0);
        rd_data = 16'hFEDC;
        get_byte(1'b0, b1);
        bus_stop();
        chk(a1 && b0 == 8'hA5, "R8 byte0 latched", 32'(b0), 32'hA5);
        chk(b1 == 8'h5A, "R8 byte1 latched", 32'(b1), 32'h5A);
    endtask

    task automatic t_restart();
        bit a1, a2;
        logic [7:0] b0;
        strap = 2'b00;
        rd_data = 16'h6B00;
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(addr_byte(2'b00, 1'b1), a1);
        get_byte(1'b0, b0);
        chk(a1 && b0 == 8'h6B, "R1 restart mid-byte", 32'(b0), 32'h6B);
        bus_start();
        put_byte(addr_byte(2'b00, 1'b0), a2);
        put_byte(8'h81, a1);
        bus_stop();
        chk(a2 && cmd == 8'h81, "R1 restart after read", 32'(cmd), 32'h81);
    endtask

    task automatic t_after_stop();
        bit a1;
        int p0, v0;
        strap = 2'b00;
        bus_start();
        bus_stop();
        p0 = pull_cycles;
        v0 = valid_cnt;
        put_byte(addr_byte(2'b00, 1'b0), a1);
        put_byte(8'h77, a1);
        bus_stop();
        chk(pull_cycles == p0 && valid_cnt == v0, "R2 no drive after stop",
            32'(pull_cycles - p0), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired R1..R10 actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        t_reset();
        for (int s = 0; s < 4; s++) t_write(2'(s), 8'h15 + 8'(s * 37));
        strap = 2'b01;
        t_bad_addr(addr_byte(2'b10, 1'b0), "strap");
        t_bad_addr(8'hB2, "upper");
        t_extra_cmd();
        t_read(16'hC36A, 1);
        t_read(16'h9E01, 2);
        t_read(16'h7F80, 3);
        t_coherent();
        t_restart();
        t_after_stop();
        chk(r9_viol == 0, "R9 pull steady while clock high", 32'(r9_viol), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule